// File: doc/BRIEF.md
# Peripheral interrupt aggregation controller

This block gathers interrupt sources from four peripheral groups of a small power-management device and presents them to a host as one combined interrupt line. The groups are a miscellaneous group with five sources (undervoltage, overvoltage, two over-temperature stages and regulator overcurrent), a temperature group and two general-purpose I/O groups, each of the last three with one source. Every group owns a bank of interrupt registers. In each bank, every source bit has its own detection mode, its own polarity selection, its own enable, and its own sticky status with a clear.

Raw sources are first brought into the clock domain. They are then qualified as edges or levels of the chosen polarity. An enabled qualifying event sets a sticky status bit, and software clears that bit by writing a one to it. A summary register has one bit per group, and each bit reports whether that group holds any enabled pending status. The host line is the OR of those bits. Software reaches all registers over a simple synchronous bus with 16-bit addresses, 8-bit data and a read result that appears one cycle after the address.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset every register reads 0x00 and irq_out is 0.
- R2: Bank n sits at base 0x0900, 0x2400, 0xC000 or 0xC100 (n = 0..3). Each bank has these offsets: live level 0x10, mode 0x11, high-polarity 0x12, low-polarity 0x13, status clear 0x14, enable set 0x15, enable clear 0x16 and sticky status 0x18. bus_rdata shows the register at bus_addr one clock after the address. Unmapped addresses read 0x00, and writes to them change nothing.
- R3: src_raw bits 4:0 feed bank 0 bits 4:0, src_raw[5] feeds bank 1 bit 0, src_raw[6] feeds bank 2 bit 0 and src_raw[7] feeds bank 3 bit 0. The live level register returns each source after a two-flop synchronizer.
- R4: Writing 1 to a bit at enable set turns that source on, and writing 1 at enable clear turns it off. A 0 bit in either write leaves the source unchanged. Both addresses read back the current enable mask. Bits with no source (7:5 in bank 0, 7:1 elsewhere) always read 0.
- R5: With mode bit 1 (edge), high-polarity=1 catches rising edges and low-polarity=1 catches falling edges. With both set, both edges are caught.
- R6: With mode bit 0 (level), high-polarity=1 catches a high level and low-polarity=1 catches a low level. The sticky bit sets again after a clear for as long as the level remains.
- R7: A sticky status bit sets only when its source is enabled.
- R8: Writing 1 to a status clear bit clears that sticky bit. If a qualifying event arrives in the same cycle, the bit stays set.
- R9: The summary register at 0x0550 is read-only. Bit n of it is the OR over bank n of sticky status AND enable, where bit 0 is misc, bit 1 is temperature, bit 2 is GPIO1 and bit 3 is GPIO2.
- R10: irq_out is the OR of the summary bits, registered one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raw | input | 8 | Asynchronous raw interrupt sources |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Combined host interrupt |

## Verification
A wrong detection mode or polarity decode shows up as a sticky status bit that is set or clear against expectation. That bit can be read about five clocks after the source moves: two for synchronization, one for the edge history and one each for the latch and the read register. A corrupted enable or sticky register appears in the same cycle in the summary register, and irq_out reflects it one clock later. A lost clear-versus-set priority leaves a sticky bit at 0 that should read 1 when the read is done right after the colliding write.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int NUM_BANKS = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 16;

  localparam logic [7:0] OFS_LIVE  = 8'h10;
  localparam logic [7:0] OFS_MODE  = 8'h11;
  localparam logic [7:0] OFS_POLH  = 8'h12;
  localparam logic [7:0] OFS_POLL  = 8'h13;
  localparam logic [7:0] OFS_CLR   = 8'h14;
  localparam logic [7:0] OFS_ENS   = 8'h15;
  localparam logic [7:0] OFS_ENC   = 8'h16;
  localparam logic [7:0] OFS_STICK = 8'h18;

  localparam logic [15:0] SUMMARY_ADDR = 16'h0550;

  function automatic logic [15:0] bank_base(int i);
    case (i)
      0:       return 16'h0900;
      1:       return 16'h2400;
      2:       return 16'hC000;
      default: return 16'hC100;
    endcase
  endfunction

  function automatic int bank_bits(int i);
    return (i == 0) ? 5 : 1;
  endfunction

  function automatic int bank_lsb(int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += bank_bits(k);
    return s;
  endfunction

  localparam int SRC_TOTAL = bank_lsb(NUM_BANKS);

  function automatic logic offset_mapped(logic [7:0] ofs);
    return (ofs >= OFS_LIVE && ofs <= OFS_ENC) || (ofs == OFS_STICK);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_aggr_pkg::*;
#(
  parameter int                BITS   = 1,
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BITS-1:0]   raw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_val,
  output logic [BITS-1:0]   stick_o,
  output logic [BITS-1:0]   en_o,
  output logic              pend
);
  localparam logic [DATA_W-1:0] USE_MASK = {DATA_W{1'b1}} >> (DATA_W - BITS);

  logic              sel;
  logic [7:0]        ofs;
  logic              wr_hit;
  logic [DATA_W-1:0] wv;
  logic [BITS-1:0]   sync_q;
  logic [DATA_W-1:0] lvl, lvl_d;
  logic [DATA_W-1:0] mode_r, polh_r, poll_r, en_r, stick_r;
  logic [DATA_W-1:0] clr_w, ens_w, enc_w;
  logic [DATA_W-1:0] edge_hit, level_hit, evt;

  irq_sync #(.W(BITS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (sync_q)
  );

  always_comb begin
    lvl = '0;
    lvl[BITS-1:0] = sync_q;
  end

  assign sel    = (addr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);
  assign ofs    = addr[7:0];
  assign wr_hit = wr && sel;
  assign wv     = wdata & USE_MASK;

  assign clr_w = (wr_hit && ofs == OFS_CLR) ? wv : '0;
  assign ens_w = (wr_hit && ofs == OFS_ENS) ? wv : '0;
  assign enc_w = (wr_hit && ofs == OFS_ENC) ? wv : '0;

  assign edge_hit  = (polh_r & lvl & ~lvl_d) | (poll_r & ~lvl & lvl_d);
  assign level_hit = (polh_r & lvl) | (poll_r & ~lvl);
  assign evt       = ((mode_r & edge_hit) | (~mode_r & level_hit)) & en_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= '0;
      mode_r  <= '0;
      polh_r  <= '0;
      poll_r  <= '0;
      en_r    <= '0;
      stick_r <= '0;
    end else begin
      lvl_d <= lvl;
      if (wr_hit && ofs == OFS_MODE) mode_r <= wv;
      if (wr_hit && ofs == OFS_POLH) polh_r <= wv;
      if (wr_hit && ofs == OFS_POLL) poll_r <= wv;
      en_r    <= (en_r | ens_w) & ~enc_w;
      stick_r <= (stick_r & ~clr_w) | evt;
    end
  end

  always_comb begin
    rd_val = '0;
    rd_hit = sel && offset_mapped(ofs);
    case (ofs)
      OFS_LIVE:         rd_val = lvl;
      OFS_MODE:         rd_val = mode_r;
      OFS_POLH:         rd_val = polh_r;
      OFS_POLL:         rd_val = poll_r;
      OFS_ENS, OFS_ENC: rd_val = en_r;
      OFS_STICK:        rd_val = stick_r;
      default:          rd_val = '0;
    endcase
    if (!rd_hit) rd_val = '0;
  end

  assign stick_o = stick_r[BITS-1:0];
  assign en_o    = en_r[BITS-1:0];
  assign pend    = |(stick_r & en_r);
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int ADDR_W = irq_aggr_pkg::ADDR_W,
  parameter int DATA_W = irq_aggr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        src_raw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int NSRC = SRC_TOTAL;

  logic [NUM_BANKS-1:0] summary;
  logic [NUM_BANKS-1:0] hit;
  logic [DATA_W-1:0]    val [NUM_BANKS];
  logic [NSRC-1:0]      stick_all;
  logic [NSRC-1:0]      en_all;
  logic [DATA_W-1:0]    rd_next;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    localparam int BITS = bank_bits(i);
    localparam int LSB  = bank_lsb(i);
    irq_bank #(
      .BITS   (BITS),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BASE   (ADDR_W'(bank_base(i)))
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .raw     (src_raw[LSB +: BITS]),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .rd_hit  (hit[i]),
      .rd_val  (val[i]),
      .stick_o (stick_all[LSB +: BITS]),
      .en_o    (en_all[LSB +: BITS]),
      .pend    (summary[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(SUMMARY_ADDR)) rd_next[NUM_BANKS-1:0] = summary;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit[i]) rd_next = rd_next | val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_out   <= |summary;
    end
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NSRC   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic [NSRC-1:0]   stick_all,
  input logic [NSRC-1:0]   en_all
);
  function automatic logic mapped(logic [ADDR_W-1:0] a);
    logic m;
    m = (a == ADDR_W'(SUMMARY_ADDR));
    for (int i = 0; i < NUM_BANKS; i++)
      if (a[ADDR_W-1:8] == bank_base(i)[15:8] && offset_mapped(a[7:0])) m = 1'b1;
    return m;
  endfunction

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && stick_all == '0 && en_all == '0));

  // R2: unmapped reads return zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !mapped($past(bus_addr)) |-> (bus_rdata == '0));

  // R4: an all-zero write never moves any enable
  p_zero_write_keeps_en_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && $past(bus_wdata) == '0) |-> $stable(en_all));

  // R7: a newly set sticky bit needs its enable
  p_set_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    ((stick_all & ~$past(stick_all) & ~$past(en_all)) == '0));

  // R10: no host interrupt without an enabled pending bit
  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(|(stick_all & en_all)) |-> !irq_out);
endmodule

bind irq_aggr_top irq_aggr_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NSRC   (NSRC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .stick_all (stick_all),
  .en_all    (en_all)
);

// File: tb/sim_irq_aggr_top.sv
`timescale 1ns/1ps
module sim_irq_aggr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic        wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_aggr_top u0 (
    .clk       (clk),
    .rst       (rst),
    .src_raw   (src),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_out   (irq)
  );

  function automatic logic [15:0] base_of(int b);
    case (b)
      0: return 16'h0900;
      1: return 16'h2400;
      2: return 16'hC000;
      default: return 16'hC100;
    endcase
  endfunction

  function automatic bit exp_stick(bit t, bit ph, bit pl, bit en, bit v0, bit v1);
    if (!en) return 0;
    if (t) return (ph && !v0 && v1) || (pl && v0 && !v1);
    return (ph && (v0 || v1)) || (pl && (!v0 || !v1));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet_all();
    for (int b = 0; b < 4; b++) begin
      wr_reg(base_of(b) + 16'h16, 8'hFF);
      wr_reg(base_of(b) + 16'h14, 8'hFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd_reg(16'h0550, r); chk("R1 summary", r, 8'h00);
    for (int b = 0; b < 4; b++) begin
      rd_reg(base_of(b) + 16'h11, r); chk("R1 mode", r, 8'h00);
      rd_reg(base_of(b) + 16'h15, r); chk("R1 enable", r, 8'h00);
      rd_reg(base_of(b) + 16'h18, r); chk("R1 sticky", r, 8'h00);
    end

    // R2: unmapped address ignored
    wr_reg(16'h0917, 8'hFF);
    rd_reg(16'h0917, r); chk("R2 unmapped read", r, 8'h00);
    wr_reg(16'h0A11, 8'hFF);
    rd_reg(16'h0911, r); chk("R2 unmapped write no effect", r, 8'h00);
    rd_reg(16'h0A11, r); chk("R2 unmapped read 2", r, 8'h00);
    wr_reg(16'h2412, 8'h01);
    rd_reg(16'h2412, r); chk("R2 temp polh", r, 8'h01);

    // R4: enable set/clear
    wr_reg(16'h0915, 8'h05);
    rd_reg(16'h0915, r); chk("R4 set read", r, 8'h05);
    rd_reg(16'h0916, r); chk("R4 clr read", r, 8'h05);
    wr_reg(16'h0915, 8'h00);
    rd_reg(16'h0915, r); chk("R4 zero set", r, 8'h05);
    wr_reg(16'h0916, 8'h01);
    rd_reg(16'h0915, r); chk("R4 clear bit0", r, 8'h04);
    wr_reg(16'h0916, 8'h00);
    rd_reg(16'h0915, r); chk("R4 zero clr", r, 8'h04);
    wr_reg(16'h0915, 8'hFF);
    rd_reg(16'h0915, r); chk("R4 misc width", r, 8'h1F);
    wr_reg(16'hC015, 8'hFF);
    rd_reg(16'hC016, r); chk("R4 gpio width", r, 8'h01);
    wr_reg(16'h0911, 8'hFF);
    rd_reg(16'h0911, r); chk("R4 mode width", r, 8'h1F);
    wr_reg(16'h0911, 8'h00);
    wr_reg(16'h2412, 8'h00);
    quiet_all();

    // R3: live level
    src = 8'hA5; idle(3);
    rd_reg(16'h0910, r); chk("R3 misc live", r, 8'h05);
    rd_reg(16'h2410, r); chk("R3 temp live", r, 8'h01);
    rd_reg(16'hC010, r); chk("R3 gpio1 live", r, 8'h00);
    rd_reg(16'hC110, r); chk("R3 gpio2 live", r, 8'h01);
    src = 8'h00; idle(3);
    rd_reg(16'hC110, r); chk("R3 gpio2 low", r, 8'h00);

    // R8: set wins over a clear in the same cycle (misc bit2, rising edge)
    wr_reg(16'h0911, 8'h04);
    wr_reg(16'h0912, 8'h04);
    wr_reg(16'h0915, 8'h04);
    idle(2);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 16'h0914; wdata = 8'h04; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(16'h0918, r); chk("R8 set wins", r, 8'h04);
    wr_reg(16'h0914, 8'h04);
    rd_reg(16'h0918, r); chk("R8 clear", r, 8'h00);
    src[2] = 1'b0;
    quiet_all();

    // R6: level re-latches while asserted (temp, high level)
    wr_reg(16'h2412, 8'h01);
    wr_reg(16'h2415, 8'h01);
    src[5] = 1'b1; idle(5);
    wr_reg(16'h2414, 8'h01);
    idle(1);
    rd_reg(16'h2418, r); chk("R6 level relatch", r, 8'h01);
    src[5] = 1'b0; idle(4);
    wr_reg(16'h2414, 8'h01); idle(1);
    rd_reg(16'h2418, r); chk("R6 level gone", r, 8'h00);
    wr_reg(16'h2412, 8'h00);
    quiet_all();

    // R9 / R10: GPIO2 summary bit, enable gating of summary and irq
    wr_reg(16'hC111, 8'h01);
    wr_reg(16'hC113, 8'h01);
    src[7] = 1'b1; idle(4);
    wr_reg(16'hC115, 8'h01);
    src[7] = 1'b0; idle(5);
    rd_reg(16'h0550, r); chk("R9 gpio2 summary bit3", r, 8'h08);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    wr_reg(16'h0550, 8'h00);
    rd_reg(16'h0550, r); chk("R9 read only", r, 8'h08);
    wr_reg(16'hC116, 8'h01); idle(1);
    rd_reg(16'h0550, r); chk("R9 disabled summary", r, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    rd_reg(16'hC118, r); chk("R9 sticky kept", r, 8'h01);
    wr_reg(16'hC115, 8'h01); idle(1);
    chk("R10 irq again", {7'd0, irq}, 8'h01);
    wr_reg(16'hC111, 8'h00);
    wr_reg(16'hC113, 8'h00);
    quiet_all();

    // R5/R6/R7 random mode sweep
    for (int it = 0; it < 48; it++) begin
      int b, bitn, idx;
      bit t, ph, pl, en, v0, v1, e;
      logic [7:0] m;
      b = $urandom_range(3);
      bitn = (b == 0) ? $urandom_range(4) : 0;
      idx = (b == 0) ? bitn : 4 + b;
      m = 8'h01 << bitn;
      t = $urandom_range(1); ph = $urandom_range(1); pl = $urandom_range(1);
      en = ($urandom_range(3) != 0); v0 = $urandom_range(1); v1 = $urandom_range(1);
      if (it < 4) begin t = 1; ph = 1; pl = 1; en = 1; v0 = it[0]; v1 = ~it[0]; end
      quiet_all();
      src[idx] = v0; idle(5);
      wr_reg(base_of(b) + 16'h14, 8'hFF);
      wr_reg(base_of(b) + 16'h11, t  ? m : 8'h00);
      wr_reg(base_of(b) + 16'h12, ph ? m : 8'h00);
      wr_reg(base_of(b) + 16'h13, pl ? m : 8'h00);
      if (en) wr_reg(base_of(b) + 16'h15, m);
      src[idx] = v1; idle(5);
      e = exp_stick(t, ph, pl, en, v0, v1);
      rd_reg(base_of(b) + 16'h18, r);
      chk(t ? "R5 edge sticky" : (en ? "R6 level sticky" : "R7 disabled sticky"),
          r, e ? m : 8'h00);
      rd_reg(16'h0550, r); chk("R9 random summary", r, e ? (8'h01 << b) : 8'h00);
      chk("R10 random irq", {7'd0, irq}, {7'd0, e});
      wr_reg(base_of(b) + 16'h11, 8'h00);
      wr_reg(base_of(b) + 16'h12, 8'h00);
      wr_reg(base_of(b) + 16'h13, 8'h00);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule